// File: doc/BRIEF.md
# Debug Single-Step and Return Sequencer

This block controls how a CPU moves between halted debug mode and normal execution when a debug host issues commands. While the CPU is halted in debug mode the host can send one of two commands. A *step* command lets the CPU run exactly one instruction, taken from the return address on top of the stack, and then forces it back into debug mode. A *resume* command releases the CPU to normal (background) execution.

The sequencer drives several outputs: the stack pop and push requests, an instruction-issue request to the core, the instruction-pointer load with the debug vector, the interrupt-enable value, fetch blocking, stall and halt, the timer enable and a 2-bit host status. The stack and the CPU datapath sit outside the block and answer through simple request/acknowledge signals. On debug entry the block saves the interrupt-enable bit. It restores that value for a step and on resume. After a resume it masks breakpoint matches until the first instruction has completed.

Top module: `dbg_step_seq`

## Requirements
- R1: Host status encodes 00 = not in debug, 01 = debug idle, 10 = busy. A step (`host_step`) or resume (`host_resume`) command is accepted only in debug idle. In the cycle after acceptance the status reads 10. If both commands arrive together, step wins.
- R2: A step produces its strobes in this order: one stack pop, one instruction issue, one stack push, one vector load. After that the status returns to 01. Only one of these four strobes is high at any time.
- R3: The instruction issued during a step or a resume uses the address returned by the stack pop.
- R4: The value pushed after a step is `cpu_next_ip`, as reported by the core with `exec_done`. This is the incremented pointer, or the interrupt vector if an interrupt was taken.
- R5: The vector load drives `ip_value` = VEC (default 16'h8010) with `cpu_halt` high and `ige_out` low. The status is 01 in the following cycle.
- R6: `ige_out` equals the interrupt-enable value latched at debug entry while an instruction is issued or executing in a step, and throughout background mode. In all other debug states it is 0.
- R7: While the return address is pushed and while the vector is loaded, `cpu_stall` and `fetch_block` are both high.
- R8: A resume produces one stack pop and then one instruction issue. After the issue is acknowledged the status is 00 and `cpu_halt` is low.
- R9: `timer_en` is high exactly when the status is 00.
- R10: In background mode, `halt_req` always enters debug mode. `bp_match` enters debug mode only after the first `exec_done` that follows a resume.
- R11: Commands that arrive while the status is 10 or 00 are ignored. They cause no stack access and no change of status.
- R12: After reset the status is 00, `cpu_halt` is low, `timer_en` is high and `ige_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_step | input | 1 | Host single-step command pulse |
| host_resume | input | 1 | Host resume command pulse |
| halt_req | input | 1 | External request to enter debug mode |
| bp_match | input | 1 | Breakpoint comparator match |
| cpu_ige | input | 1 | Core's interrupt-enable bit, latched on debug entry |
| stk_pop_ack | input | 1 | Stack pop acknowledge |
| stk_pop_data | input | AW | Popped return address |
| stk_push_ack | input | 1 | Stack push acknowledge |
| insn_ack | input | 1 | Core accepted the issued instruction |
| exec_done | input | 1 | Core finished an instruction |
| cpu_next_ip | input | AW | Next instruction pointer reported with exec_done |
| stk_pop_req | output | 1 | Stack pop request |
| stk_push_req | output | 1 | Stack push request |
| stk_push_data | output | AW | Address to push |
| insn_req | output | 1 | Issue one instruction to the core |
| insn_addr | output | AW | Address of the issued instruction |
| ip_load | output | 1 | Load instruction pointer |
| ip_value | output | AW | Value for the pointer load |
| ige_out | output | 1 | Interrupt-enable value driven to the core |
| fetch_block | output | 1 | Block program-memory fetch |
| cpu_stall | output | 1 | Stall the core pipeline |
| cpu_halt | output | 1 | Halt the core |
| timer_en | output | 1 | Enable internal timers |
| host_status | output | 2 | Status reported to the host |

## Verification
A corrupted sequencer state shows up in the next cycle as a wrong status code or as a missing, extra or reordered strobe. The scoreboard catches this at the first strobe edge that is out of order. A lost saved interrupt-enable bit is not visible until the next instruction issue or resume, where `ige_out` is wrong. A suppression flag stuck in either value shows only when a breakpoint match arrives in background mode: it causes either an early re-entry into debug, or no re-entry after `exec_done`.

// File: rtl/dbg_step_seq_pkg.sv
package dbg_step_seq_pkg;

    typedef enum logic [1:0] {
        HS_RUN  = 2'b00,
        HS_IDLE = 2'b01,
        HS_BUSY = 2'b10
    } host_stat_e;

    typedef enum logic [3:0] {
        S_BG,
        S_DIDLE,
        S_T_POP,
        S_T_ISSUE,
        S_T_EXEC,
        S_T_PUSH,
        S_T_VEC,
        S_R_POP,
        S_R_ISSUE
    } seq_state_e;

endpackage

// File: rtl/dbg_bp_guard.sv
module dbg_bp_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic in_bg,
    input  logic arm,
    input  logic retire,
    input  logic halt_req,
    input  logic bp_match,
    output logic enter,
    output logic supp
);
    logic supp_d, supp_q;

    always_comb begin
        supp_d = supp_q;
        if (arm)
            supp_d = 1'b1;
        else if (in_bg && retire)
            supp_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) supp_q <= 1'b0;
        else        supp_q <= supp_d;
    end

    assign enter = in_bg && (halt_req || (bp_match && !supp_q));
    assign supp  = supp_q;
endmodule

// File: rtl/dbg_step_seq.sv
module dbg_step_seq
    import dbg_step_seq_pkg::*;
#(
    parameter int          AW  = 16,
    parameter logic [AW-1:0] VEC = 16'h8010
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_step,
    input  logic          host_resume,
    input  logic          halt_req,
    input  logic          bp_match,
    input  logic          cpu_ige,
    input  logic          stk_pop_ack,
    input  logic [AW-1:0] stk_pop_data,
    input  logic          stk_push_ack,
    input  logic          insn_ack,
    input  logic          exec_done,
    input  logic [AW-1:0] cpu_next_ip,
    output logic          stk_pop_req,
    output logic          stk_push_req,
    output logic [AW-1:0] stk_push_data,
    output logic          insn_req,
    output logic [AW-1:0] insn_addr,
    output logic          ip_load,
    output logic [AW-1:0] ip_value,
    output logic          ige_out,
    output logic          fetch_block,
    output logic          cpu_stall,
    output logic          cpu_halt,
    output logic          timer_en,
    output logic [1:0]    host_status
);
    typedef struct packed {
        seq_state_e    state;
        logic [AW-1:0] ret_addr;
        logic          saved_ige;
    } seq_regs_t;

    seq_regs_t r_d, r_q;
    logic      enter, bp_supp, in_bg, arm;
    logic      saved_ige;

    assign in_bg     = (r_q.state == S_BG);
    assign arm       = (r_q.state == S_R_ISSUE) && insn_ack;
    assign saved_ige = r_q.saved_ige;

    dbg_bp_guard u_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_bg    (in_bg),
        .arm      (arm),
        .retire   (exec_done),
        .halt_req (halt_req),
        .bp_match (bp_match),
        .enter    (enter),
        .supp     (bp_supp)
    );

    // next-state
    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            S_BG: if (enter) begin
                r_d.state     = S_DIDLE;
                r_d.saved_ige = cpu_ige;
            end
            S_DIDLE: begin
                if (host_step)        r_d.state = S_T_POP;
                else if (host_resume) r_d.state = S_R_POP;
            end
            S_T_POP: if (stk_pop_ack) begin
                r_d.ret_addr = stk_pop_data;
                r_d.state    = S_T_ISSUE;
            end
            S_T_ISSUE: if (insn_ack) r_d.state = S_T_EXEC;
            S_T_EXEC: if (exec_done) begin
                r_d.ret_addr = cpu_next_ip;
                r_d.state    = S_T_PUSH;
            end
            S_T_PUSH: if (stk_push_ack) r_d.state = S_T_VEC;
            S_T_VEC:  r_d.state = S_DIDLE;
            S_R_POP: if (stk_pop_ack) begin
                r_d.ret_addr = stk_pop_data;
                r_d.state    = S_R_ISSUE;
            end
            S_R_ISSUE: if (insn_ack) r_d.state = S_BG;
            default: r_d.state = S_DIDLE;
        endcase
    end

    // output decode
    always_comb begin
        stk_pop_req   = 1'b0;
        stk_push_req  = 1'b0;
        insn_req      = 1'b0;
        ip_load       = 1'b0;
        ige_out       = 1'b0;
        fetch_block   = 1'b0;
        cpu_stall     = 1'b0;
        cpu_halt      = 1'b1;
        timer_en      = 1'b0;
        host_status   = HS_BUSY;
        stk_push_data = r_q.ret_addr;
        insn_addr     = r_q.ret_addr;
        ip_value      = VEC;
        unique case (r_q.state)
            S_BG: begin
                cpu_halt    = 1'b0;
                timer_en    = 1'b1;
                ige_out     = r_q.saved_ige;
                host_status = HS_RUN;
            end
            S_DIDLE: host_status = HS_IDLE;
            S_T_POP, S_R_POP: stk_pop_req = 1'b1;
            S_T_ISSUE, S_R_ISSUE: begin
                insn_req = 1'b1;
                cpu_halt = 1'b0;
                ige_out  = r_q.saved_ige;
            end
            S_T_EXEC: begin
                cpu_halt = 1'b0;
                ige_out  = r_q.saved_ige;
            end
            S_T_PUSH: begin
                stk_push_req = 1'b1;
                cpu_stall    = 1'b1;
                fetch_block  = 1'b1;
            end
            S_T_VEC: begin
                ip_load     = 1'b1;
                cpu_stall   = 1'b1;
                fetch_block = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state     <= S_BG;
            r_q.ret_addr  <= '0;
            r_q.saved_ige <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/dbg_step_seq_chk.sv
module dbg_step_seq_chk #(
    parameter int            AW  = 16,
    parameter logic [AW-1:0] VEC = 16'h8010
) (
    input logic          clk,
    input logic          rst_n,
    input logic          host_step,
    input logic          host_resume,
    input logic          halt_req,
    input logic          bp_match,
    input logic          stk_pop_req,
    input logic          stk_push_req,
    input logic          insn_req,
    input logic          ip_load,
    input logic [AW-1:0] ip_value,
    input logic          ige_out,
    input logic          fetch_block,
    input logic          cpu_stall,
    input logic          cpu_halt,
    input logic          timer_en,
    input logic [1:0]    host_status,
    input logic          saved_ige,
    input logic          bp_supp
);
    a_r1_cmd_to_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (host_status == 2'b01 && (host_step || host_resume)) |=> host_status == 2'b10);

    a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({stk_pop_req, insn_req, stk_push_req, ip_load}));

    a_r5_vector_load: assert property (@(posedge clk) disable iff (!rst_n)
        ip_load |-> (ip_value == VEC && cpu_halt && !ige_out));

    a_r5_idle_after_vec: assert property (@(posedge clk) disable iff (!rst_n)
        ip_load |=> host_status == 2'b01);

    a_r6_ige_on_issue: assert property (@(posedge clk) disable iff (!rst_n)
        insn_req |-> ige_out == saved_ige);

    a_r7_push_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        stk_push_req |-> (cpu_stall && fetch_block));

    a_r9_timer_run_only: assert property (@(posedge clk) disable iff (!rst_n)
        timer_en |-> (host_status == 2'b00 && !cpu_halt));

    a_r10_bp_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (host_status == 2'b00 && bp_supp && bp_match && !halt_req) |=> host_status == 2'b00);

    a_r11_busy_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (host_status == 2'b10 && !ip_load && !insn_req) |=> host_status != 2'b00);
endmodule

bind dbg_step_seq dbg_step_seq_chk #(.AW(AW), .VEC(VEC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_step   (host_step),
    .host_resume (host_resume),
    .halt_req    (halt_req),
    .bp_match    (bp_match),
    .stk_pop_req (stk_pop_req),
    .stk_push_req(stk_push_req),
    .insn_req    (insn_req),
    .ip_load     (ip_load),
    .ip_value    (ip_value),
    .ige_out     (ige_out),
    .fetch_block (fetch_block),
    .cpu_stall   (cpu_stall),
    .cpu_halt    (cpu_halt),
    .timer_en    (timer_en),
    .host_status (host_status),
    .saved_ige   (saved_ige),
    .bp_supp     (bp_supp)
);

// File: tb/dbg_step_seq_bench.sv
module dbg_step_seq_bench;
    localparam int AW = 16;
    localparam logic [AW-1:0] IRQ_VEC = 16'h0040;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic host_step = 0, host_resume = 0, halt_req = 0, bp_match = 0, cpu_ige = 0;
    logic stk_pop_ack = 0, stk_push_ack = 0, insn_ack = 0, exec_done = 0;
    logic [AW-1:0] stk_pop_data = '0, cpu_next_ip = '0;
    logic stk_pop_req, stk_push_req, insn_req, ip_load, ige_out, fetch_block;
    logic cpu_stall, cpu_halt, timer_en;
    logic [AW-1:0] stk_push_data, insn_addr, ip_value;
    logic [1:0] host_status;

    dbg_step_seq u_dbg_step_seq (.*);

    int n_chk = 0, n_fail = 0;
    logic irq_mode = 0, auto_done = 1, man_done = 0, pend = 0;
    logic exp_ige = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // stub core and stack
    always @(negedge clk) begin
        stk_pop_ack  = stk_pop_req && !stk_pop_ack;
        stk_push_ack = stk_push_req && !stk_push_ack;
        exec_done    = pend | man_done;
        pend         = 1'b0;
        if (insn_req && !insn_ack) begin
            insn_ack    = 1'b1;
            cpu_next_ip = irq_mode ? IRQ_VEC : insn_addr + 1'b1;
            pend        = auto_done;
        end else begin
            insn_ack = 1'b0;
        end
    end

    // scoreboard: 1 pop, 2 issue, 3 push, 4 vector load
    int            q_kind[$];
    logic [AW-1:0] q_val[$];
    string         q_req[$];

    task automatic expect_ev(input int k, input logic [AW-1:0] v, input string req);
        q_kind.push_back(k);
        q_val.push_back(v);
        q_req.push_back(req);
    endtask

    task automatic observe(input int k, input logic [AW-1:0] v);
        if (q_kind.size() == 0) begin
            chk(1'b0, "R11", "unexpected strobe", k, 0);
        end else begin
            int ek = q_kind.pop_front();
            logic [AW-1:0] ev = q_val.pop_front();
            string er = q_req.pop_front();
            chk(ek == k, er, "strobe order", k, ek);
            if (ek == k && k != 1) chk(v == ev, (k == 3) ? "R4" : (k == 2) ? "R3" : "R5",
                                       "strobe value", int'(v), int'(ev));
        end
    endtask

    logic p_pop = 0, p_iss = 0, p_push = 0, p_ld = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (stk_pop_req && !p_pop) observe(1, '0);
            if (insn_req && !p_iss) begin
                observe(2, insn_addr);
                chk(ige_out == exp_ige, "R6", "ige during issue", ige_out, exp_ige);
            end
            if (stk_push_req && !p_push) begin
                observe(3, stk_push_data);
                chk(cpu_stall && fetch_block, "R7", "stall/block on push",
                    {cpu_stall, fetch_block}, 3);
            end
            if (ip_load && !p_ld) begin
                observe(4, ip_value);
                chk(cpu_halt && !ige_out && fetch_block, "R5", "halt/ige/block on vector",
                    {cpu_halt, ige_out, fetch_block}, 5);
            end
        end
        p_pop = stk_pop_req; p_iss = insn_req; p_push = stk_push_req; p_ld = ip_load;
    end

    task automatic wait_status(input logic [1:0] s, input string req);
        int n = 0;
        while (host_status != s && n < 60) begin @(negedge clk); n++; end
        chk(host_status == s, req, "status reached", host_status, s);
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: host_step = 1;
            1: host_resume = 1;
            2: halt_req = 1;
            default: man_done = 1;
        endcase
        @(negedge clk);
        host_step = 0; host_resume = 0; halt_req = 0; man_done = 0;
    endtask

    task automatic do_step(input logic [AW-1:0] top, input logic irq, input string req);
        stk_pop_data = top;
        irq_mode = irq;
        expect_ev(1, '0, "R2");
        expect_ev(2, top, "R2");
        expect_ev(3, irq ? IRQ_VEC : top + 1'b1, "R2");
        expect_ev(4, 16'h8010, "R2");
        pulse(0);
        chk(host_status == 2'b10, "R1", "busy after step cmd", host_status, 2);
        pulse(1);   // resume while busy: R11 ignored
        wait_status(2'b01, "R2");
        chk(q_kind.size() == 0, "R2", "all step strobes seen", q_kind.size(), 0);
        chk(cpu_halt && !ige_out && !timer_en, "R5", "halted idle after step",
            {cpu_halt, ige_out, timer_en}, 4);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(host_status == 2'b00 && !cpu_halt && timer_en && !ige_out, "R12", "reset state",
            {host_status, cpu_halt, timer_en, ige_out}, 4'b0010);

        // R11: step in background is ignored
        pulse(0);
        repeat (3) @(negedge clk);
        chk(host_status == 2'b00, "R11", "step ignored in background", host_status, 0);

        // enter with interrupts enabled
        cpu_ige = 1;
        pulse(2);
        @(negedge clk);
        chk(host_status == 2'b01, "R10", "halt_req enters debug", host_status, 1);
        chk(!timer_en && !ige_out, "R9", "timers off, ige cleared in debug",
            {timer_en, ige_out}, 0);

        exp_ige = 1;
        do_step(16'h1234, 1'b0, "R2");
        repeat (4) @(negedge clk);
        chk(host_status == 2'b01, "R11", "resume during busy ignored", host_status, 1);
        do_step(16'h1235, 1'b1, "R4");

        // resume
        auto_done = 0;
        stk_pop_data = 16'h2000;
        expect_ev(1, '0, "R8");
        expect_ev(2, 16'h2000, "R8");
        pulse(1);
        wait_status(2'b00, "R8");
        chk(!cpu_halt && timer_en, "R9", "timers on after resume", {cpu_halt, timer_en}, 1);
        chk(ige_out == 1'b1, "R6", "ige restored in background", ige_out, 1);

        // breakpoint masked until first completion
        cpu_ige = 0;
        @(negedge clk); bp_match = 1;
        repeat (3) @(negedge clk);
        chk(host_status == 2'b00, "R10", "bp masked after resume", host_status, 0);
        pulse(3);
        repeat (2) @(negedge clk);
        chk(host_status == 2'b01, "R10", "bp breaks after first completion", host_status, 1);
        bp_match = 0;

        auto_done = 1;
        exp_ige = 0;
        do_step(16'h3000, 1'b0, "R6");

        // resume, then halt_req while masked still enters
        auto_done = 0;
        stk_pop_data = 16'h3001;
        expect_ev(1, '0, "R8");
        expect_ev(2, 16'h3001, "R8");
        pulse(1);
        wait_status(2'b00, "R8");
        chk(ige_out == 1'b0, "R6", "ige restored as 0", ige_out, 0);
        pulse(2);
        @(negedge clk);
        chk(host_status == 2'b01, "R10", "halt_req enters while bp masked", host_status, 1);

        repeat (3) @(negedge clk);
        chk(q_kind.size() == 0, "R2", "scoreboard drained", q_kind.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule